// File: doc/BRIEF.md
# Calendar Time Counter with Posted-Write Handshake

This block holds a wall-clock calendar: hours, minutes and seconds in one packed word, and day, month, year offset and a leap-year flag in a second packed word. A one-cycle `tick` pulse, produced elsewhere from the slow oscillator, advances the seconds. Rollover ripples up through minutes, hours, days, months and years. The day rollover follows the length of each month, and February takes its length from the stored leap flag. The year field counts from a base year of 1970, so the range runs from 1970 to 2033. When the year advances, the leap flag is recomputed from the new year.

Software reaches the block through a small register port. A read returns data combinationally. A write to the time word or the date word is posted. The written value is held in a pending register, and a per-word busy flag in the control word rises. The running counter keeps its old value until a commit state machine loads the pending value, after a fixed hold of `COMMIT_CYC` cycles. Each word has its own commit machine with three states:
- `CM_IDLE`: no write is pending.
- `CM_HOLD`: entered from `CM_IDLE` on an accepted write. It counts `COMMIT_CYC` cycles.
- `CM_APPLY`: entered from `CM_HOLD` when the count is done. It loads the counter and returns to `CM_IDLE` in the next cycle.

Software polls the busy flag before and after each write. While the flag is set, further writes to that word are dropped. The counter can advance between two reads, so software reading both words should read twice and compare.

Top module: `cal_rtc`

## Requirements
- R1: After reset the time word reads 0 (00:00:00), the date word reads 0x00000101 (day 1, month 1, year offset 0, leap 0), and both busy flags are clear.
- R2: Register layout:
  - The time word is at offset 0x14, with seconds in bits [5:0], minutes in bits [13:8] and hours in bits [20:16].
  - The date word is at offset 0x10, with day in bits [4:0], month in bits [11:8], year offset in bits [21:16] and the leap flag in bit 22.
  - The control word is at offset 0x00. The time-busy flag is bit 8 and the date-busy flag is bit 7. All other bits of the control word read 0.
- R3: Each `tick` pulse advances seconds by one. Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day. Nothing changes without a tick.
- R4: The day wraps to 1 and the month advances after day 30 in months 4, 6, 9 and 11, and after day 31 in months 1, 3, 5, 7, 8, 10 and 12.
- R5: February ends after day 29 when the leap flag is 1, and after day 28 when it is 0.
- R6: After December 31 the date becomes January 1 of the next year offset, with 63 wrapping to 0. The new leap flag is 1 exactly when (year offset + 2) mod 4 = 0.
- R7: A write to the time word or the date word sets that word's busy flag for exactly COMMIT_CYC+1 cycles. The flag is first seen in the cycle after the write. Until the flag clears, the word still reads the running value. When the flag clears, the word reads the written value.
- R8: A write to a word whose busy flag is set is ignored. The earlier pending value is the one committed.
- R9: When a commit and a tick fall in the same cycle, the committed word takes the written value. A time commit discards any day carry, so the date is unchanged. A date commit overrides the carry, while the time still advances on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse that advances the calendar by one second |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
A commit and a tick can fall in the same cycle. Either the time word or the date word can be the one being committed, so the collision comes in two forms. The bench provokes each form by counting from the write strobe to the `CM_APPLY` cycle and raising `tick` there, with the time preset to 23:59:59 so that the tick would carry into the day. For each form it judges both words against the rule in R9: the committed word must hold exactly the written value, and the other word must show, or not show, the effect of the carry.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sc;
    } hms_t;

    typedef struct packed {
        logic       leap;
        logic [5:0] yr;
        logic [3:0] mo;
        logic [4:0] dy;
    } ymd_t;

    typedef enum logic [1:0] {
        CM_IDLE,
        CM_HOLD,
        CM_APPLY
    } cm_state_t;

    localparam int TBUSY_BIT = 8;
    localparam int DBUSY_BIT = 7;
    localparam int W_DATE    = 0;
    localparam int W_TIME    = 1;
    localparam int N_WORDS   = 2;

    localparam ymd_t DATE_AT_RESET = '{leap: 1'b0, yr: 6'd0, mo: 4'd1, dy: 5'd1};

    function automatic logic [4:0] month_days(input logic [3:0] mo, input logic leap);
        logic [4:0] n;
        unique case (mo)
            4'd2:                       n = leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:    n = 5'd30;
            default:                    n = 5'd31;
        endcase
        return n;
    endfunction

    function automatic logic [31:0] pack_hms(input hms_t t);
        return {11'd0, t.hr, 2'd0, t.mn, 2'd0, t.sc};
    endfunction

    function automatic logic [31:0] pack_ymd(input ymd_t d);
        return {9'd0, d.leap, d.yr, 4'd0, d.mo, 3'd0, d.dy};
    endfunction

    function automatic hms_t unpack_hms(input logic [31:0] w);
        hms_t t;
        t.hr = w[20:16];
        t.mn = w[13:8];
        t.sc = w[5:0];
        return t;
    endfunction

    function automatic ymd_t unpack_ymd(input logic [31:0] w);
        ymd_t d;
        d.leap = w[22];
        d.yr   = w[21:16];
        d.mo   = w[11:8];
        d.dy   = w[4:0];
        return d;
    endfunction

endpackage

// File: rtl/cal_commit_fsm.sv
module cal_commit_fsm
    import cal_pkg::*;
#(
    parameter int COMMIT_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    output logic busy,
    output logic apply
);
    localparam int CW = $clog2(COMMIT_CYC) + 1;
    localparam logic [CW-1:0] LAST = CW'(COMMIT_CYC - 1);

    cm_state_t       state_q, state_d;
    logic [CW-1:0]   hold_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CM_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 hold_cnt <= '0;
        else if (state_q == CM_HOLD) hold_cnt <= hold_cnt + 1'b1;
        else                        hold_cnt <= '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CM_IDLE:  if (wr_req) state_d = CM_HOLD;
            CM_HOLD:  if (hold_cnt == LAST) state_d = CM_APPLY;
            CM_APPLY: state_d = CM_IDLE;
            default:  state_d = CM_IDLE;
        endcase
    end

    always_comb begin
        busy  = (state_q != CM_IDLE);
        apply = (state_q == CM_APPLY);
    end

endmodule

// File: rtl/cal_time_unit.sv
module cal_time_unit
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    input  hms_t load_val,
    output hms_t cur,
    output logic day_step
);
    logic sc_end, mn_end, hr_end;

    always_comb begin
        sc_end   = (cur.sc >= 6'd59);
        mn_end   = (cur.mn >= 6'd59);
        hr_end   = (cur.hr >= 5'd23);
        day_step = tick && !load && sc_end && mn_end && hr_end;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= load_val;
        end else if (tick) begin
            if (!sc_end) begin
                cur.sc <= cur.sc + 6'd1;
            end else begin
                cur.sc <= '0;
                if (!mn_end) begin
                    cur.mn <= cur.mn + 6'd1;
                end else begin
                    cur.mn <= '0;
                    cur.hr <= hr_end ? 5'd0 : cur.hr + 5'd1;
                end
            end
        end
    end

endmodule

// File: rtl/cal_date_unit.sv
module cal_date_unit
    import cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic load,
    input  ymd_t load_val,
    output ymd_t cur
);
    logic [5:0] yr_next;
    logic       month_end, year_end;

    always_comb begin
        month_end = (cur.dy >= month_days(cur.mo, cur.leap));
        year_end  = (cur.mo >= 4'd12);
        yr_next   = cur.yr + 6'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= DATE_AT_RESET;
        end else if (load) begin
            cur <= load_val;
        end else if (step) begin
            if (!month_end) begin
                cur.dy <= cur.dy + 5'd1;
            end else begin
                cur.dy <= 5'd1;
                if (!year_end) begin
                    cur.mo <= cur.mo + 4'd1;
                end else begin
                    cur.mo   <= 4'd1;
                    cur.yr   <= yr_next;
                    cur.leap <= (yr_next[1:0] == 2'd2);
                end
            end
        end
    end

endmodule

// File: rtl/cal_rtc.sv
module cal_rtc
    import cal_pkg::*;
#(
    parameter int COMMIT_CYC = 2,
    parameter int ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
    parameter logic [ADDR_W-1:0] DATE_OFS = 'h10,
    parameter logic [ADDR_W-1:0] TIME_OFS = 'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    logic [N_WORDS-1:0] wr_hit, wr_req, busy, apply;
    hms_t  pend_t, cur_t;
    ymd_t  pend_d, cur_d;
    logic  day_step;
    logic [31:0] time_word, date_word;
    logic  unused_wdata;

    assign unused_wdata = ^{bus_wdata[31:23], bus_wdata[15:14], bus_wdata[7:6]};

    assign wr_hit[W_TIME] = bus_we && (bus_addr == TIME_OFS);
    assign wr_hit[W_DATE] = bus_we && (bus_addr == DATE_OFS);
    assign wr_req         = wr_hit & ~busy;

    for (genvar g = 0; g < N_WORDS; g++) begin : g_commit
        cal_commit_fsm #(.COMMIT_CYC(COMMIT_CYC)) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_req (wr_req[g]),
            .busy   (busy[g]),
            .apply  (apply[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_t <= '0;
            pend_d <= DATE_AT_RESET;
        end else begin
            if (wr_req[W_TIME]) pend_t <= unpack_hms(bus_wdata);
            if (wr_req[W_DATE]) pend_d <= unpack_ymd(bus_wdata);
        end
    end

    cal_time_unit u_time (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (apply[W_TIME]),
        .load_val (pend_t),
        .cur      (cur_t),
        .day_step (day_step)
    );

    cal_date_unit u_date (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (day_step),
        .load     (apply[W_DATE]),
        .load_val (pend_d),
        .cur      (cur_d)
    );

    assign time_word = pack_hms(cur_t);
    assign date_word = pack_ymd(cur_d);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == TIME_OFS) begin
            bus_rdata = time_word;
        end else if (bus_addr == DATE_OFS) begin
            bus_rdata = date_word;
        end else if (bus_addr == CTRL_OFS) begin
            bus_rdata[TBUSY_BIT] = busy[W_TIME];
            bus_rdata[DBUSY_BIT] = busy[W_DATE];
        end
    end

endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk #(
    parameter int COMMIT_CYC = 2,
    parameter int ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] DATE_OFS = 'h10,
    parameter logic [ADDR_W-1:0] TIME_OFS = 'h14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       time_word,
    input logic [31:0]       date_word,
    input logic              t_busy,
    input logic              d_busy
);
    localparam int CW = $clog2(COMMIT_CYC + 2) + 1;

    logic [CW-1:0] t_run, d_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_run <= '0;
            d_run <= '0;
        end else begin
            t_run <= t_busy ? t_run + 1'b1 : '0;
            d_run <= d_busy ? d_run + 1'b1 : '0;
        end
    end

    // R7
    t_busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(t_busy) |-> $past(bus_we && bus_addr == TIME_OFS));

    // R7
    d_busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(d_busy) |-> $past(bus_we && bus_addr == DATE_OFS));

    // R7
    t_busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(t_busy) |-> $past(t_run) == CW'(COMMIT_CYC));

    // R7
    d_busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(d_busy) |-> $past(d_run) == CW'(COMMIT_CYC));

    // R3
    time_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(time_word) |-> ($past(tick) || $fell(t_busy)));

    // R4
    date_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(date_word) |-> ($past(tick) || $fell(d_busy)));

endmodule

bind cal_rtc cal_rtc_chk #(
    .COMMIT_CYC (COMMIT_CYC),
    .ADDR_W     (ADDR_W),
    .DATE_OFS   (DATE_OFS),
    .TIME_OFS   (TIME_OFS)
) u_cal_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .time_word (time_word),
    .date_word (date_word),
    .t_busy    (busy[cal_pkg::W_TIME]),
    .d_busy    (busy[cal_pkg::W_DATE])
);

// File: tb/cal_rtc_bench.sv
module cal_rtc_bench;
    localparam int COMMIT_CYC = 2;
    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_DATE = 8'h10;
    localparam logic [7:0] A_TIME = 8'h14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    cal_rtc #(.COMMIT_CYC(COMMIT_CYC)) u_cal_rtc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    function automatic logic [31:0] mk_time(int h, int m, int s);
        return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    function automatic logic [31:0] mk_date(int leap, int y, int mo, int d);
        return (32'(leap) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
    endfunction

    function automatic int days_in(int mo, int leap);
        if (mo == 2) return leap ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic bit is_last_sec(logic [31:0] t);
        return t[20:16] == 23 && t[13:8] == 59 && t[5:0] == 59;
    endfunction

    function automatic logic [31:0] next_time(logic [31:0] t);
        int h = t[20:16], m = t[13:8], s = t[5:0];
        s++;
        if (s == 60) begin s = 0; m++; end
        if (m == 60) begin m = 0; h++; end
        if (h == 24) h = 0;
        return mk_time(h, m, s);
    endfunction

    function automatic logic [31:0] next_date(logic [31:0] dt);
        int lp = dt[22], y = dt[21:16], mo = dt[11:8], d = dt[4:0];
        if (d < days_in(mo, lp)) return mk_date(lp, y, mo, d + 1);
        if (mo < 12) return mk_date(lp, y, mo + 1, 1);
        y = (y + 1) % 64;
        return mk_date(((y + 2) % 4 == 0) ? 1 : 0, y, 1, 1);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] c;
        for (int i = 0; i < 20; i++) begin
            rd(A_CTRL, c);
            if (c == 0) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic set_both(logic [31:0] t, logic [31:0] d);
        wr(A_TIME, t); wait_idle();
        wr(A_DATE, d); wait_idle();
    endtask

    task automatic day_roll(string req, logic [31:0] d_in, logic [31:0] d_exp);
        logic [31:0] v;
        set_both(mk_time(23, 59, 59), d_in);
        pulse_tick();
        rd(A_DATE, v); chk(req, v, d_exp);
        rd(A_TIME, v); chk(req, v, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] v, mt, md;
        int n;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_TIME, v); chk("R1 time", v, 32'd0);
        rd(A_DATE, v); chk("R1 date", v, 32'h0000_0101);
        rd(A_CTRL, v); chk("R1 ctrl", v, 32'd0);

        // R7 posted write, busy length, old value visible; R2 busy bit position
        wr(A_TIME, mk_time(23, 59, 58));
        rd(A_TIME, v); chk("R7 old value while busy", v, 32'd0);
        rd(A_CTRL, v); chk("R2 ctrl bit8 only", v, 32'h0000_0100);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            rd(A_CTRL, v);
            if (v == 0) break;
            n++;
            @(negedge clk);
        end
        chk("R7 busy cycles", 32'(n), 32'(COMMIT_CYC + 1));
        rd(A_TIME, v); chk("R2 time readback", v, 32'h0017_3B3A);
        wr(A_DATE, mk_date(0, 0, 1, 1));
        rd(A_CTRL, v); chk("R2 ctrl bit7 only", v, 32'h0000_0080);
        wait_idle();

        // R3 rollover chain
        repeat (5) @(negedge clk);
        rd(A_TIME, v); chk("R3 no tick no change", v, 32'h0017_3B3A);
        pulse_tick();
        rd(A_TIME, v); chk("R3 sec", v, mk_time(23, 59, 59));
        pulse_tick();
        rd(A_TIME, v); chk("R3 midnight", v, 32'd0);
        rd(A_DATE, v); chk("R3 day carry", v, mk_date(0, 0, 1, 2));
        wr(A_TIME, mk_time(10, 14, 59)); wait_idle();
        pulse_tick();
        rd(A_TIME, v); chk("R3 minute carry", v, mk_time(10, 15, 0));

        // R4 month lengths
        day_roll("R4 Apr30", mk_date(0, 5, 4, 30), mk_date(0, 5, 5, 1));
        day_roll("R4 Jan31", mk_date(0, 5, 1, 31), mk_date(0, 5, 2, 1));
        day_roll("R4 Jan30", mk_date(0, 5, 1, 30), mk_date(0, 5, 1, 31));
        // R5 February
        day_roll("R5 Feb28 leap", mk_date(1, 2, 2, 28), mk_date(1, 2, 2, 29));
        day_roll("R5 Feb29 leap", mk_date(1, 2, 2, 29), mk_date(1, 2, 3, 1));
        day_roll("R5 Feb28 plain", mk_date(0, 3, 2, 28), mk_date(0, 3, 3, 1));
        // R6 year rollover
        day_roll("R6 to leap", mk_date(0, 1, 12, 31), mk_date(1, 2, 1, 1));
        day_roll("R6 from leap", mk_date(1, 2, 12, 31), mk_date(0, 3, 1, 1));
        day_roll("R6 wrap 63", mk_date(0, 63, 12, 31), mk_date(0, 0, 1, 1));

        // R8 write while busy ignored
        wr(A_TIME, mk_time(5, 6, 7));
        wr(A_TIME, mk_time(8, 9, 10));
        wait_idle();
        rd(A_TIME, v); chk("R8 time second write dropped", v, mk_time(5, 6, 7));
        wr(A_DATE, mk_date(0, 9, 7, 4));
        wr(A_DATE, mk_date(0, 9, 8, 8));
        wait_idle();
        rd(A_DATE, v); chk("R8 date second write dropped", v, mk_date(0, 9, 7, 4));

        // R9 time commit and tick in the same cycle
        set_both(mk_time(23, 59, 59), mk_date(0, 0, 1, 2));
        wr(A_TIME, mk_time(10, 0, 0));
        repeat (COMMIT_CYC - 1) @(negedge clk);
        pulse_tick();
        rd(A_TIME, v); chk("R9 time commit wins", v, mk_time(10, 0, 0));
        rd(A_DATE, v); chk("R9 no day carry", v, mk_date(0, 0, 1, 2));
        // R9 date commit and tick in the same cycle
        wr(A_TIME, mk_time(23, 59, 59)); wait_idle();
        wr(A_DATE, mk_date(0, 0, 3, 5));
        repeat (COMMIT_CYC - 1) @(negedge clk);
        pulse_tick();
        rd(A_DATE, v); chk("R9 date commit wins", v, mk_date(0, 0, 3, 5));
        rd(A_TIME, v); chk("R9 time still advances", v, 32'd0);

        // R3 R4 R5 R6 random runs against the bench model
        for (int it = 0; it < 40; it++) begin
            int mo, y, lp;
            mo = 1 + int'($urandom_range(11));
            y  = int'($urandom_range(63));
            lp = ((y + 2) % 4 == 0) ? 1 : 0;
            if (it % 4 == 0) mo = 12;
            md = mk_date(lp, y, mo, 1 + int'($urandom_range(days_in(mo, lp) - 1)));
            mt = mk_time(int'($urandom_range(23)), int'($urandom_range(59)),
                         int'($urandom_range(59)));
            if (it % 2 == 0) begin
                md = mk_date(lp, y, mo, days_in(mo, lp));
                mt = mk_time(23, 59, 60 - 1 - int'($urandom_range(5)));
            end
            set_both(mt, md);
            n = 1 + int'($urandom_range(79));
            for (int k = 0; k < n; k++) begin
                if (is_last_sec(mt)) md = next_date(md);
                mt = next_time(mt);
                pulse_tick();
            end
            rd(A_TIME, v); chk("R3 random time", v, mt);
            rd(A_DATE, v); chk("R6 random date", v, md);
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule